// File: doc/BRIEF.md
# Reference Clock Loss Detector

The detector watches a slow reference clock (or a divided copy of it) from the domain of a free-running local oscillator. The reference is brought into the oscillator domain through a short flop chain, and its rising edges are picked out there. An interval counter clocked by the oscillator returns to zero at every detected reference edge and otherwise advances by one per oscillator cycle. If the counter reaches the threshold before another edge arrives, the loss flag goes high. The next reference edge clears it.

Detection only runs when the enable is high and scan mode is low. In every other case the counter is held at zero and the flag is held low. Once detection is allowed again, timing starts over with a full window. The counter stops at the threshold, so an absent reference can never make it wrap and clear the flag by mistake.

Top module: `clk_loss_det`

## Requirements
- R1: During and after an active-low asynchronous reset on `rst_ni`, `loss_o` is 0 until a full threshold window has elapsed with detection active.
- R2: A reference toggling with a period shorter than THRESH oscillator cycles never raises `loss_o`.
- R3: Let edge n be the first oscillator rising edge that samples the reference high after it was low. If no later reference rise occurs and detection stays active, `loss_o` goes to 1 right after oscillator edge n+THRESH+3 (THRESH = 64 by default).
- R4: While `loss_o` is 1, it returns to 0 right after oscillator edge n+2, where n is the first edge that samples a new reference rise. This is within 3 oscillator cycles.
- R5: While the reference stays absent, `loss_o` stays 1 indefinitely. The interval counter saturates and does not wrap.
- R6: While `scan_mode_i` is 1, `loss_o` is 0 from the next oscillator edge onward. After release, a complete window of THRESH+1 active edges with no reference rise is needed before `loss_o` rises.
- R7: While `en_i` is 0, `loss_o` is 0 from the next oscillator edge onward and the counter is cleared. After re-enable, the same full-window rule as R6 applies.
- R8: Boundary: a reference period of exactly THRESH+1 oscillator cycles never raises `loss_o`. A period of THRESH+2 raises it for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock (asynchronous to clk_i) |
| en_i | input | 1 | Detector enable, active high |
| scan_mode_i | input | 1 | Scan mode; suppresses detection when high |
| loss_o | output | 1 | Reference loss flag |

## Verification
The bench aims at the off-by-one window edges. A period of THRESH+1 must stay silent, while THRESH+2 must produce single-cycle pulses. A counter that compared one step early or late would either flag a healthy reference or miss a dead one. Long absences test saturation: a wrapping counter would let the flag drop after a few hundred cycles. Toggling the enable and scan mode mid-window checks that detection restarts with a full window; a design that kept the stale count would raise the flag too early after release. Clearing is checked at its exact cycle, which exposes any synchroniser depth that differs from the one specified.

// File: rtl/clk_loss_pkg.sv
package clk_loss_pkg;
  localparam int unsigned DEF_THRESH = 64;
  localparam int unsigned DEF_SYNC   = 2;

  function automatic int unsigned cnt_width(input int unsigned thresh);
    return $clog2(thresh + 1);
  endfunction
endpackage

// File: rtl/clk_loss_sync.sv
module clk_loss_sync #(
  parameter int unsigned STAGES = clk_loss_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], ref_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R4
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/clk_loss_cnt.sv
module clk_loss_cnt #(
  parameter int unsigned THRESH = clk_loss_pkg::DEF_THRESH,
  localparam int unsigned CW = clk_loss_pkg::cnt_width(THRESH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          rise_i,
  output logic          full_o
);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!active_i)        cnt_q <= '0;
    else if (rise_i)           cnt_q <= '0;
    else if (cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == LIMIT);

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && rise_i) |=> (cnt_q == '0));
  // R5
  saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !rise_i && full_o) |=> full_o);
  // R7
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/clk_loss_flag.sv
module clk_loss_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic rise_i,
  input  logic full_i,
  output logic loss_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        loss_o <= 1'b0;
    else if (!active_i) loss_o <= 1'b0;
    else if (rise_i)    loss_o <= 1'b0;
    else if (full_i)    loss_o <= 1'b1;
  end

  // R6
  inactive_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !loss_o);
  // R4
  edge_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !loss_o);
  // R3
  set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_o) |-> $past(full_i));
endmodule

// File: rtl/clk_loss_det.sv
module clk_loss_det #(
  parameter int unsigned THRESH = clk_loss_pkg::DEF_THRESH,
  parameter int unsigned STAGES = clk_loss_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic en_i,
  input  logic scan_mode_i,
  output logic loss_o
);
  logic active, rise, full;

  assign active = en_i & ~scan_mode_i;

  clk_loss_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .ref_i(ref_clk_i), .rise_o(rise)
  );

  clk_loss_cnt #(.THRESH(THRESH)) u_cnt (
    .clk_i, .rst_ni, .active_i(active), .rise_i(rise), .full_o(full)
  );

  clk_loss_flag u_flag (
    .clk_i, .rst_ni, .active_i(active), .rise_i(rise), .full_i(full), .loss_o
  );

  // R2
  no_early_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full && !loss_o) |=> !loss_o);
endmodule

// File: tb/sim_clk_loss_det.sv
module sim_clk_loss_det;
  localparam int THRESH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_clk = 1'b0, en = 1'b0, scan = 1'b0;
  logic loss;
  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit   ready = 1'b0;

  // bench reference state
  bit h0, h1, h2;
  int gap;
  bit exp_loss;

  always #2 clk = ~clk;

  clk_loss_det #(.THRESH(THRESH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk),
    .en_i(en), .scan_mode_i(scan), .loss_o(loss)
  );

  function automatic bit seen_rise(input bit a, input bit b);
    return a && !b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; gap = 0; exp_loss = 0;
    end else begin
      if (!(en && !scan) || seen_rise(h1, h2)) begin
        gap = 0; exp_loss = 0;
      end else begin
        if (gap >= THRESH) exp_loss = 1;
        if (gap < THRESH) gap++;
      end
      h2 = h1; h1 = h0; h0 = ref_clk;
    end
  end

  always @(negedge clk) if (ready) begin
    checks++;
    if (loss !== exp_loss) begin
      errors++;
      $display("FAIL %s t=%0t loss_o actual %b expected %b", cur_req, $time, loss, exp_loss);
    end
  end

  task automatic step(input bit r, input bit e, input bit s);
    @(negedge clk);
    ref_clk = r; en = e; scan = s;
  endtask

  task automatic periods(input int p, input int n);
    for (int i = 0; i < n; i++)
      for (int c = 0; c < p; c++) step(c < p / 2, en, scan);
  endtask

  task automatic hold(input bit r, input int n);
    for (int i = 0; i < n; i++) step(r, en, scan);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cur_req = "R1";
    ready = 1'b1;
    repeat (3) @(negedge clk);
    // reset state seen directly
    checks++;
    if (loss !== 1'b0) begin
      errors++; $display("FAIL R1 loss_o in reset actual %b expected 0", loss);
    end
    rst_n = 1'b1;
    step(0, 1, 0);
    hold(0, THRESH - 4);            // R1: still low inside first window
    cur_req = "R2";
    periods(20, 15);
    periods(3, 40);
    cur_req = "R8";
    periods(THRESH + 1, 5);          // never flags
    periods(THRESH + 2, 5);          // one-cycle pulse per period
    cur_req = "R3";
    step(1, 1, 0);
    hold(1, THRESH + 10);            // static high is not an edge
    cur_req = "R5";
    hold(0, 1000);
    cur_req = "R4";
    hold(1, 6);
    hold(0, THRESH + 10);
    hold(1, 4);
    cur_req = "R6";
    hold(0, THRESH + 5);
    step(0, 1, 1);
    hold(0, 30);
    step(0, 1, 0);
    hold(0, THRESH + 5);
    periods(10, 3);
    hold(0, 30);
    step(0, 1, 1);
    step(0, 1, 0);
    hold(0, THRESH + 3);
    cur_req = "R7";
    step(0, 0, 0);
    hold(0, 40);
    step(0, 1, 0);
    hold(0, THRESH + 4);
    step(1, 0, 0);
    hold(1, 5);
    step(0, 1, 0);
    hold(0, 20);
    // random mix
    cur_req = "R2";
    for (int k = 0; k < 60; k++) begin
      int p = 2 + int'($urandom % 90);
      bit e = ($urandom % 8) != 0;
      bit s = ($urandom % 10) == 0;
      cur_req = (p <= THRESH) ? "R2" : "R3";
      if (!e) cur_req = "R7";
      else if (s) cur_req = "R6";
      for (int c = 0; c < p; c++) step(c < p / 2, e, s);
    end
    cur_req = "R5";
    step(0, 1, 0);
    hold(0, 300);
    ready = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule